// File: doc/BRIEF.md
# Configurable dual pipeline register

The block keeps two banks of eight data registers, called bank A and bank B. A 2-bit operation code is sampled on each rising clock edge and controls how data moves:

- Both banks can advance together. Bank A then feeds bank B, so the two act as one sixteen-stage delay line.
- Either bank can advance alone while the other keeps its contents.
- Nothing moves at all.

Any one of the sixteen stages can be read at any time through a 4-bit stage select. The read path is combinational and does not depend on the operation code, so a read and a shift can be issued in the same cycle.

The output models a three-state driver as a data bus plus a drive flag. When the driver is off, the data bus reads as zero. Typical uses are delay equalisation with a tap chosen at run time, and two independent eight-deep histories kept side by side.

Top module: `dual_pipe_reg`

## Requirements
- R1: While `rst_ni` is low, all sixteen stages are cleared to zero, independently of the clock. After reset, every stage select reads zero.
- R2: Operation code 2'b00 advances both banks on the rising edge. `din_i` enters A0, each A stage moves up one place, A7 moves into B0, each B stage moves up one place, and the old B7 value is dropped.
- R3: Operation code 2'b01 advances bank B only. `din_i` enters B0, each B stage moves up one place, the old B7 is dropped, and bank A is unchanged.
- R4: Operation code 2'b10 advances bank A only. `din_i` enters A0, each A stage moves up one place, the old A7 is dropped, and bank B is unchanged.
- R5: Operation code 2'b11 changes no stage, and the value of `din_i` has no effect.
- R6: Stage select values 0 to 7 read A0 to A7, and values 8 to 15 read B0 to B7. The read is combinational from the current stage contents and the select.
- R7: A shift becomes visible on `dout_o` only after the clock edge that performs it. In the cycle before that edge, the output still shows the old contents.
- R8: When `oe_ni` is high, `dout_o` is zero and `dout_en_o` is low. When `oe_ni` is low, `dout_en_o` is high and `dout_o` carries the selected stage. `oe_ni` never alters the stage contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation code: 00 both, 01 B only, 10 A only, 11 hold |
| din_i | input | 8 | Data entering A0 or B0 |
| sel_i | input | 4 | Stage select: 0-7 A0-A7, 8-15 B0-B7 |
| oe_ni | input | 1 | Output enable, active low |
| dout_o | output | 8 | Selected stage, zero when disabled |
| dout_en_o | output | 1 | High when the output drives |

## Verification
A read and a shift can land in the same cycle. Every step of the bench sets a stage select and an operation code together.

Before the edge, the output is compared with a queue model of the old contents. After the edge, the model is updated and the new contents are checked in the next step. Selects that point at A7 and B0 while a joint shift is issued show whether a value crosses the cascade exactly once. The output enable is toggled during those same steps to show that gating the driver has no effect on the shifting.

// File: rtl/dual_pipe_reg_pkg.sv
package dual_pipe_reg_pkg;
  typedef enum logic [1:0] {
    OP_SHIFT_BOTH = 2'b00,
    OP_SHIFT_B    = 2'b01,
    OP_SHIFT_A    = 2'b10,
    OP_HOLD       = 2'b11
  } op_e;
endpackage

// File: rtl/dpr_ctrl.sv
module dpr_ctrl
  import dual_pipe_reg_pkg::*;
(
  input  op_e  op_i,
  output logic shift_a_o,
  output logic shift_b_o,
  output logic cascade_o
);
  always_comb begin
    shift_a_o = 1'b0;
    shift_b_o = 1'b0;
    cascade_o = 1'b0;
    unique case (op_i)
      OP_SHIFT_BOTH: begin
        shift_a_o = 1'b1;
        shift_b_o = 1'b1;
        cascade_o = 1'b1;
      end
      OP_SHIFT_B: shift_b_o = 1'b1;
      OP_SHIFT_A: shift_a_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/dpr_bank.sv
module dpr_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shift_i,
  input  logic [DATA_W-1:0]       din_i,
  output logic [DEPTH*DATA_W-1:0] stages_o
);
  logic [DEPTH-1:0][DATA_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (shift_i) begin
      stage_q[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign stages_o = stage_q;
endmodule

// File: rtl/dpr_read_mux.sv
module dpr_read_mux #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 16,
  parameter int SEL_W  = $clog2(TAPS)
) (
  input  logic [TAPS*DATA_W-1:0] taps_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic [DATA_W-1:0]      data_o
);
  logic [DATA_W-1:0] tap_arr [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tap_arr[g] = taps_i[g*DATA_W +: DATA_W];
  end

  assign data_o = tap_arr[sel_i];
endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);
  assign dout_en_o = ~oe_ni;
  assign dout_o    = oe_ni ? '0 : data_i;
endmodule

// File: rtl/dual_pipe_reg.sv
module dual_pipe_reg
  import dual_pipe_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int TAPS  = 2 * DEPTH,
  localparam int SEL_W = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);
  op_e                    op;
  logic                   shift_a, shift_b, cascade;
  logic [DEPTH*DATA_W-1:0] a_flat, b_flat;
  logic [DATA_W-1:0]       b_din, rd_data;

  assign op = op_e'(op_i);

  dpr_ctrl u_ctrl (
    .op_i      (op),
    .shift_a_o (shift_a),
    .shift_b_o (shift_b),
    .cascade_o (cascade)
  );

  dpr_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank_a (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (shift_a),
    .din_i    (din_i),
    .stages_o (a_flat)
  );

  // last A stage feeds B0 on a joint shift
  assign b_din = cascade ? a_flat[(DEPTH-1)*DATA_W +: DATA_W] : din_i;

  dpr_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank_b (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (shift_b),
    .din_i    (b_din),
    .stages_o (b_flat)
  );

  dpr_read_mux #(.DATA_W(DATA_W), .TAPS(TAPS), .SEL_W(SEL_W)) u_mux (
    .taps_i (({b_flat, a_flat})),
    .sel_i  (sel_i),
    .data_o (rd_data)
  );

  dpr_out_stage #(.DATA_W(DATA_W)) u_out (
    .oe_ni     (oe_ni),
    .data_i    (rd_data),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o)
  );
endmodule

// File: rtl/dual_pipe_reg_checker.sv
module dual_pipe_reg_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [1:0]              op_i,
  input logic [DATA_W-1:0]       din_i,
  input logic                    oe_ni,
  input logic [DATA_W-1:0]       dout_o,
  input logic                    dout_en_o,
  input logic [DEPTH*DATA_W-1:0] a_flat_i,
  input logic [DEPTH*DATA_W-1:0] b_flat_i
);
  localparam int LAST = (DEPTH-1)*DATA_W;

  assert_both_cascade_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b00 |=> a_flat_i[DATA_W-1:0] == $past(din_i)
                   && b_flat_i[DATA_W-1:0] == $past(a_flat_i[LAST +: DATA_W]));

  assert_b_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b01 |=> $stable(a_flat_i) && b_flat_i[DATA_W-1:0] == $past(din_i));

  assert_a_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b10 |=> $stable(b_flat_i) && a_flat_i[DATA_W-1:0] == $past(din_i));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b11 |=> $stable(a_flat_i) && $stable(b_flat_i));

  assert_off_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (dout_o == '0) && !dout_en_o);

  assert_on_drives_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> dout_en_o);
endmodule

bind dual_pipe_reg dual_pipe_reg_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .din_i     (din_i),
  .oe_ni     (oe_ni),
  .dout_o    (dout_o),
  .dout_en_o (dout_en_o),
  .a_flat_i  (a_flat),
  .b_flat_i  (b_flat)
);

// File: tb/dual_pipe_reg_bench.sv
`timescale 1ns/1ps
module dual_pipe_reg_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] op_i = 2'b11;
  logic [7:0] din_i = '0;
  logic [3:0] sel_i = '0;
  logic       oe_ni = 1'b0;
  logic [7:0] dout_o;
  logic       dout_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] qa[$];
  logic [7:0] qb[$];

  always #2.5 clk_i = ~clk_i;

  dual_pipe_reg u_dual_pipe_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .din_i(din_i),
    .sel_i(sel_i), .oe_ni(oe_ni), .dout_o(dout_o), .dout_en_o(dout_en_o)
  );

  task automatic model_clear();
    qa.delete(); qb.delete();
    for (int i = 0; i < 8; i++) begin qa.push_back(8'h00); qb.push_back(8'h00); end
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] s);
    return (s < 8) ? qa[s] : qb[s-8];
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual en/data=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // drive, compare pre-edge output, clock, update model
  task automatic step(input string tag, input logic [1:0] op, input logic [7:0] d,
                      input logic [3:0] s, input logic oe_n);
    logic [7:0] t;
    op_i = op; din_i = d; sel_i = s; oe_ni = oe_n;
    #1;
    check(tag, {dout_en_o, dout_o}, oe_n ? 9'h000 : {1'b1, model_read(s)});
    @(posedge clk_i);
    case (op)
      2'b00: begin
        t = qa.pop_back(); qa.push_front(d);
        void'(qb.pop_back()); qb.push_front(t);
      end
      2'b01: begin void'(qb.pop_back()); qb.push_front(d); end
      2'b10: begin void'(qa.pop_back()); qa.push_front(d); end
      default: ;
    endcase
    #1;
  endtask

  task automatic read_all(input string tag);
    for (int s = 0; s < 16; s++) step(tag, 2'b11, 8'($urandom), 4'(s), 1'b0);
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state on every select while reset is held
    for (int s = 0; s < 16; s++) begin
      sel_i = 4'(s); #0.1;
      check("R1", {dout_en_o, dout_o}, 9'h100);
    end
    rst_ni = 1'b1;
    #1;
    read_all("R1");

    // R2: fill the 16-deep pipe, value crosses A7->B0
    for (int i = 0; i < 20; i++) step("R2", 2'b00, 8'(8'h10 + i), 4'(i % 16), 1'b0);
    read_all("R6");
    // R7: watch A7 and B0 across joint shifts
    for (int i = 0; i < 6; i++) step("R7", 2'b00, 8'(8'hA0 + i), (i % 2) ? 4'd8 : 4'd7, 1'b0);

    // R3: B only, A must stay
    for (int i = 0; i < 5; i++) step("R3", 2'b01, 8'(8'hB0 + i), 4'd8, 1'b0);
    read_all("R3");
    // R4: A only, B must stay
    for (int i = 0; i < 5; i++) step("R4", 2'b10, 8'(8'hC0 + i), 4'd0, 1'b0);
    read_all("R4");
    // R5: hold with changing data
    for (int i = 0; i < 6; i++) step("R5", 2'b11, 8'($urandom), 4'(i), 1'b0);
    read_all("R5");

    // R8: output disabled while shifting, contents still advance
    for (int i = 0; i < 8; i++) step("R8", 2'(i % 4), 8'(8'hE0 + i), 4'(i * 2), 1'b1);
    read_all("R8");

    // mixed traffic
    for (int i = 0; i < 400; i++)
      step("R6", 2'($urandom), 8'($urandom), 4'($urandom), 1'($urandom % 4 == 0));

    // R1: asynchronous reset mid-run
    op_i = 2'b00; din_i = 8'h5A;
    #0.5; rst_ni = 1'b0; #0.5;
    sel_i = 4'd7; #0.1;
    check("R1", {dout_en_o, dout_o}, 9'h100);
    model_clear();
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    read_all("R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule